// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers inquire cycles from an external bus master against a small direct-mapped table of cache lines. Each line holds a tag and a two-bit coherence state. The master puts a line address, an even parity bit and an invalidate flag on the inputs, then pulls the active-low strobe `eads_n` low for one clock.

Two clocks later the block reports three results. It drives a hit indication and a modified-hit indication. It also pulses an address parity error output when the parity check fails. When the inquire hits, the line is moved to Invalid or Shared, as the invalidate flag selects.

A modified hit keeps `hitm_n` low until the master signals that the line has been written back. While that is pending, the block refuses further inquires. A local fill port loads tags and states into the table.

Top module: `snoop_responder`

## Requirements
- R1: After reset, `hit_n`, `hitm_n` and `apchk_n` are high, and every line is Invalid, so any inquire misses.
- R2: An inquire is taken on a rising edge where `eads_n` is low. `snp_line`, `snp_par` and `snp_inv` are captured on that same edge. Its results appear on the second rising edge after it.
- R3: The index is `snp_line[2:0]` (byte address bits 7:5) and the tag is `snp_line[26:3]`. The result is a hit when that index holds a non-Invalid state with an equal tag. `hit_n` goes low on a hit and high on a miss.
- R4: `hit_n` changes only when an inquire result is delivered, and it holds its value between inquires.
- R5: `hitm_n` goes low with the result of a hit on a Modified line (state code 3). It stays low until `wb_done` is sampled high, and goes high on that edge.
- R6: Parity is even over `{snp_line, snp_par}`. For each inquire with odd parity, `apchk_n` is low for exactly one clock. The lookup and state update proceed regardless of the parity result.
- R7: On a hit, the line becomes Invalid (code 0) when `snp_inv` is 1. It becomes Shared (code 1) when `snp_inv` is 0, from Modified, Exclusive or Shared. A miss changes no line.
- R8: A strobe is ignored while `hitm_n` is low. It is also ignored while an earlier inquire that hit a Modified line has not yet delivered its result. An ignored strobe changes no output and no line.
- R9: A rising edge with `fill_en` high writes the tag and `fill_st` into the line indexed by `fill_line`. The state codes are I=0, S=1, E=2, M=3. If an inquire update falls on the same index on the same edge, the inquire update wins.
- R10: Strobes on consecutive clocks are answered on consecutive clocks, in order. The second lookup sees the line state left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eads_n | input | 1 | Inquire strobe, active low |
| snp_line | input | 27 | Inquire line address (byte address bits 31:5) |
| snp_par | input | 1 | Even parity bit for `snp_line` |
| snp_inv | input | 1 | Invalidate request, sampled with the strobe |
| wb_done | input | 1 | Write-back done, releases `hitm_n` |
| fill_en | input | 1 | Table write enable |
| fill_line | input | 27 | Line address to write |
| fill_st | input | 2 | State to write (I=0, S=1, E=2, M=3) |
| hit_n | output | 1 | Inquire hit, active low, held between inquires |
| hitm_n | output | 1 | Modified-line hit, active low |
| apchk_n | output | 1 | Address parity error, active low, one-clock pulse |

## Verification
The assertions assume the master never pulses `wb_done` in the same cycle that a modified hit result is delivered. They also assume that fills do not race an inquire on the same index, except in the one case that R9 defines.

The stimulus keeps to these assumptions. It pulses `wb_done` only after it has seen `hitm_n` low. It issues fills only between inquires, apart from one directed collision.

Strobes are sent at or behind the modified-hit lockout only in directed cases, where the bench expects them to be dropped. The random traffic draws tags from a small pool so that hits, Modified lines and parity faults all occur often.

// File: rtl/snoop_responder.sv
module snoop_responder #(
  parameter int LINE_W = 27,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eads_n,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              snp_par,
  input  logic              snp_inv,
  input  logic              wb_done,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [1:0]        fill_st,
  output logic              hit_n,
  output logic              hitm_n,
  output logic              apchk_n
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = LINE_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd3;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [1:0]       st_q  [DEPTH];

  logic              s1_v, s1_par, s1_inv;
  logic [LINE_W-1:0] s1_line;
  logic              s2_v, s2_hit, s2_mod, s2_perr;

  logic [IDX_W-1:0] s1_idx, f_idx;
  logic             s1_hit, s1_mod, s1_perr, mh_pend, accept;

  assign s1_idx  = s1_line[IDX_W-1:0];
  assign f_idx   = fill_line[IDX_W-1:0];
  assign s1_hit  = (st_q[s1_idx] != ST_I) && (tag_q[s1_idx] == s1_line[LINE_W-1:IDX_W]);
  assign s1_mod  = s1_hit && (st_q[s1_idx] == ST_M);
  assign s1_perr = ^{s1_line, s1_par};
  assign mh_pend = (s1_v && s1_mod) || (s2_v && s2_mod);
  assign accept  = !eads_n && hitm_n && !mh_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_line <= '0; s1_par <= 1'b0; s1_inv <= 1'b0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_line <= snp_line; s1_par <= snp_par; s1_inv <= snp_inv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      if (fill_en) begin
        st_q[f_idx]  <= fill_st;
        tag_q[f_idx] <= fill_line[LINE_W-1:IDX_W];
      end
      if (s1_v && s1_hit) st_q[s1_idx] <= s1_inv ? ST_I : ST_S;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_hit <= 1'b0; s2_mod <= 1'b0; s2_perr <= 1'b0;
    end else begin
      s2_v    <= s1_v;
      s2_hit  <= s1_hit;
      s2_mod  <= s1_mod;
      s2_perr <= s1_perr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_n <= 1'b1; hitm_n <= 1'b1; apchk_n <= 1'b1;
    end else begin
      apchk_n <= !(s2_v && s2_perr);
      if (s2_v) hit_n <= !s2_hit;
      if (!hitm_n && wb_done) hitm_n <= 1'b1;
      if (s2_v && s2_mod) hitm_n <= 1'b0;
    end
  end

  a_r4_hit_only_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_n != $past(hit_n)) |-> $past(s2_v));
  a_r6_perr_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    !apchk_n |-> $past(s2_v));
  a_r5_hitm_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !hitm_n |-> !hit_n);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitm_n && wb_done) |=> hitm_n);
  a_r8_strobe_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!hitm_n && !eads_n) |=> !s1_v);
endmodule

// File: tb/snoop_responder_tb.sv
module snoop_responder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic eads_n = 1'b1, snp_par = 1'b0, snp_inv = 1'b0, wb_done = 1'b0, fill_en = 1'b0;
  logic [26:0] snp_line = '0, fill_line = '0;
  logic [1:0] fill_st = '0;
  logic hit_n, hitm_n, apchk_n;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0]  m_st  [8];
  logic [23:0] m_tag [8];

  always #10 clk = ~clk;

  snoop_responder u_dut (.clk(clk), .rst_n(rst_n), .eads_n(eads_n), .snp_line(snp_line),
    .snp_par(snp_par), .snp_inv(snp_inv), .wb_done(wb_done), .fill_en(fill_en),
    .fill_line(fill_line), .fill_st(fill_st), .hit_n(hit_n), .hitm_n(hitm_n), .apchk_n(apchk_n));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [26:0] l);
    return (m_st[l[2:0]] != 2'd0) && (m_tag[l[2:0]] == l[26:3]);
  endfunction

  function automatic logic [26:0] mk(input int tag, input int idx);
    return {24'(tag), 3'(idx)};
  endfunction

  task automatic fill(input logic [26:0] l, input logic [1:0] st);
    fill_en = 1; fill_line = l; fill_st = st;
    m_st[l[2:0]] = st; m_tag[l[2:0]] = l[26:3];
    @(negedge clk); fill_en = 0;
  endtask

  task automatic model(input logic [26:0] l, input bit inv, output bit h, output bit m);
    h = m_hit(l);
    m = h && (m_st[l[2:0]] == 2'd3);
    if (h) m_st[l[2:0]] = inv ? 2'd0 : 2'd1;
  endtask

  task automatic strobe(input logic [26:0] l, input bit inv, input bit bad);
    eads_n = 0; snp_line = l; snp_inv = inv; snp_par = (^l) ^ bad;
  endtask

  task automatic release_hitm();
    chk(hitm_n == 0, "R5", "hitm held before writeback", hitm_n, 0);
    wb_done = 1; @(negedge clk); wb_done = 0;
    chk(hitm_n == 1, "R5", "hitm released", hitm_n, 1);
  endtask

  task automatic snoop(input logic [26:0] l, input bit inv, input bit bad, input string req);
    bit h, m;
    model(l, inv, h, m);
    strobe(l, inv, bad);
    @(negedge clk); eads_n = 1;
    @(negedge clk);
    chk(apchk_n == 1, "R2", "no result after one clock", apchk_n, 1);
    @(negedge clk);
    chk(hit_n == !h, req, "hit_n", hit_n, !h);
    chk(hitm_n == !m, "R5", "hitm_n", hitm_n, !m);
    chk(apchk_n == !bad, "R6", "apchk_n", apchk_n, !bad);
    @(negedge clk);
    chk(apchk_n == 1, "R6", "apchk one clock", apchk_n, 1);
    chk(hit_n == !h, "R4", "hit_n held", hit_n, !h);
    if (m) release_hitm();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    chk(hit_n == 1 && hitm_n == 1 && apchk_n == 1, "R1", "outputs in reset",
        {hit_n, hitm_n, apchk_n}, 7);
    rst_n = 1; @(negedge clk);
    snoop(mk(0, 0), 0, 0, "R1");
    fill(mk(5, 2), 2'd2);
    snoop(mk(5, 2), 0, 0, "R3");
    snoop(mk(6, 2), 0, 0, "R3");
    snoop(mk(5, 2), 0, 0, "R7");
    snoop(mk(5, 2), 1, 1, "R7");
    snoop(mk(5, 2), 0, 0, "R7");
    fill(mk(9, 4), 2'd3);
    snoop(mk(9, 4), 0, 0, "R5");
    snoop(mk(9, 4), 0, 0, "R7");

    // R10 back to back strobes, first with a parity fault
    begin
      bit h1, m1, h2, m2;
      fill(mk(3, 1), 2'd1);
      model(mk(3, 1), 1, h1, m1);
      model(mk(3, 1), 0, h2, m2);
      strobe(mk(3, 1), 1, 1); @(negedge clk);
      strobe(mk(3, 1), 0, 0); @(negedge clk); eads_n = 1;
      @(negedge clk);
      chk(hit_n == !h1 && apchk_n == 0, "R10", "first result", {hit_n, apchk_n}, {!h1, 1'b0});
      @(negedge clk);
      chk(hit_n == !h2 && apchk_n == 1, "R10", "second result", {hit_n, apchk_n}, {!h2, 1'b1});
    end

    // R8 strobes dropped behind a modified hit
    fill(mk(7, 5), 2'd3);
    fill(mk(2, 6), 2'd1);
    begin
      bit h, m;
      model(mk(7, 5), 1, h, m);
      strobe(mk(7, 5), 1, 0); @(negedge clk);
      strobe(mk(1, 3), 0, 1); @(negedge clk); eads_n = 1;
      @(negedge clk);
      chk(hit_n == 0 && hitm_n == 0, "R8", "modified hit", {hit_n, hitm_n}, 0);
      repeat (2) begin
        @(negedge clk);
        chk(hit_n == 0 && apchk_n == 1, "R8", "pending strobe dropped", {hit_n, apchk_n}, 1);
      end
      strobe(mk(2, 6), 1, 0); @(negedge clk); eads_n = 1;
      repeat (3) @(negedge clk);
      chk(hit_n == 0 && apchk_n == 1, "R8", "strobe under hitm dropped", {hit_n, apchk_n}, 1);
      release_hitm();
      snoop(mk(2, 6), 0, 0, "R8");
    end

    // R9 fill and inquire update on the same index and edge
    begin
      bit h, m;
      fill(mk(4, 7), 2'd1);
      model(mk(4, 7), 1, h, m);
      strobe(mk(4, 7), 1, 0); @(negedge clk); eads_n = 1;
      fill_en = 1; fill_line = mk(4, 7); fill_st = 2'd2;
      @(negedge clk); fill_en = 0;
      @(negedge clk);
      chk(hit_n == 0, "R9", "hit before collision", hit_n, 0);
      @(negedge clk);
      snoop(mk(4, 7), 0, 0, "R9");
    end

    for (int it = 0; it < 300; it++) begin
      int t, x;
      t = ($urandom % 8 == 0) ? 24'hFFFFFF : int'($urandom % 2);
      x = int'($urandom % 8);
      if ($urandom % 4 == 0) fill(mk(t, x), 2'($urandom % 4));
      else snoop(mk(t, x), bit'($urandom % 2), ($urandom % 8) == 0, "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule